// File: doc/BRIEF.md
# Multiplexed Host-Port Bus Master

This block lets on-chip logic perform single read and write transfers to an external processor through a multiplexed host port. A 16-bit bus is shared between the two devices. Each transfer starts with a control phase and ends with a data phase. An internal requester raises a request with a direction, two control bits and, for writes, a data word. The block answers with a one-cycle grant. It then runs a fixed, clock-spaced strobe sequence on the host pins and finishes with a one-cycle done pulse. On a read, that pulse comes with the captured word.

The block produces the direction, chip-select, address-strobe and data-strobe pins directly from flip-flops. Because the spacing between edges is set by whole clock cycles, the interface times itself without reference to the processor's clock. The bus leaves the block as a data word plus an output enable for the pad buffer. The pad drives the word when the enable is high and floats the pin otherwise. Three handshake inputs are registered before use:
- The ready flag gates the read data strobe.
- The transfer acknowledge is presented on an output after registering.
- The service request is presented on an output after registering.

Top module: `hpm_master`

## Requirements
- R1: While reset is held, `hp_cs_n`, `hp_as_n`, `hp_ds_n` and `hp_rnw` are 1, and `hp_oe`, `rsp_done`, `req_grant`, `ack_seen` and `svc_pending` are 0.
- R2: `hp_rnw` takes the transfer direction (1 = read, 0 = write) exactly two cycles before `hp_cs_n` falls. It holds that value until the done cycle.
- R3: `hp_as_n` falls exactly one cycle after `hp_cs_n` falls, and both stay low until the data strobe is released.
- R4: On a write, `hp_ds_n` falls exactly one cycle after `hp_as_n` falls and is low for exactly one cycle. `hp_dout` equals the write word while `hp_ds_n` is low and in the cycle in which it rises.
- R5: In the cycle `hp_cs_n` falls and in the cycle `hp_as_n` falls, `hp_oe` is 1. In those cycles `hp_dout` carries the request's control bits in bits [1:0], with zeros above.
- R6: On a read, `hp_oe` is 1 only in the two control-phase cycles and is 0 from the cycle after `hp_as_n` falls. On a write, `hp_oe` stays 1 through the cycle in which `hp_ds_n` rises and is 0 in the next cycle. `hp_oe` is never 1 while the processor drives the bus.
- R7: On a read, `hp_ds_n` falls exactly two cycles after the cycle in which `hp_ready` is first seen high (one cycle for the input register, one for the state machine), and never before.
- R8: On a read, the bus value present in the last cycle `hp_ds_n` is low appears on `rsp_rdata` in the done cycle.
- R9: `req_grant` pulses for one cycle, one cycle after `req_valid` is seen in idle. `rsp_done` pulses for one cycle, in the cycle the data strobe rises, with `hp_cs_n`, `hp_as_n` and `hp_ds_n` all 1.
- R10: `ack_seen` and `svc_pending` follow `hp_ack` and `hp_svc` one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Transfer request, held until grant |
| req_write | input | 1 | 1 = write, 0 = read |
| req_ctrl | input | CTRL_W | Control bits sent in the control phase |
| req_wdata | input | DATA_W | Write word |
| req_grant | output | 1 | One-cycle acceptance pulse |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W | Read word, valid with done |
| hp_cs_n | output | 1 | Chip select, active low |
| hp_as_n | output | 1 | Address/control strobe, active low |
| hp_ds_n | output | 1 | Data strobe, active low |
| hp_rnw | output | 1 | Direction to processor, 1 = read |
| hp_dout | output | DATA_W | Word for the bus pad |
| hp_oe | output | 1 | Pad output enable |
| hp_din | input | DATA_W | Bus value from the pad |
| hp_ready | input | 1 | Processor ready flag |
| hp_ack | input | 1 | Processor transfer acknowledge |
| hp_svc | input | 1 | Processor service request |
| ack_seen | output | 1 | Registered acknowledge |
| svc_pending | output | 1 | Registered service request |

## Verification
The assertions assume that the requester holds `req_valid` until it sees the grant and makes no new request before done. They also assume that the processor raises ready only after the address strobe has fallen and drops it once chip select returns high. The bench's requester task and its behavioural responder follow these rules. The responder drives the bus only while chip select and the data strobe are low during a read. It waits a random number of cycles before raising ready, so the ready-gated strobe is exercised over several wait lengths.

// File: rtl/hpm_pkg.sv
package hpm_pkg;

    localparam int HP_DATA_W = 16;
    localparam int HP_CTRL_W = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD1,
        ST_LEAD2,
        ST_SEL,
        ST_ADDR,
        ST_WAIT,
        ST_STROBE,
        ST_CLOSE
    } hp_state_e;

    typedef struct packed {
        logic cs_n;
        logic as_n;
        logic ds_n;
        logic rnw;
    } hp_pins_t;

    // Pin levels that belong to a state; wr selects the direction level.
    function automatic hp_pins_t pins_for(hp_state_e s, logic wr);
        hp_pins_t p;
        p.cs_n = 1'b1;
        p.as_n = 1'b1;
        p.ds_n = 1'b1;
        p.rnw  = ~wr;
        case (s)
            ST_IDLE:   p.rnw  = 1'b1;
            ST_SEL:    p.cs_n = 1'b0;
            ST_ADDR,
            ST_WAIT: begin
                p.cs_n = 1'b0;
                p.as_n = 1'b0;
            end
            ST_STROBE: begin
                p.cs_n = 1'b0;
                p.as_n = 1'b0;
                p.ds_n = 1'b0;
            end
            default: ;
        endcase
        return p;
    endfunction

    // Enable register window. It is issued one state early, because the
    // output-enable stage adds a register of delay and a one-cycle stretch.
    function automatic logic drive_window(hp_state_e s, logic wr);
        logic en;
        en = 1'b0;
        case (s)
            ST_LEAD2:       en = 1'b1;
            ST_SEL, ST_ADDR: en = wr;
            default:        en = 1'b0;
        endcase
        return en;
    endfunction

endpackage

// File: rtl/hpm_insync.sv
module hpm_insync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end
endmodule

// File: rtl/hpm_oe_stage.sv
module hpm_oe_stage (
    input  logic clk,
    input  logic rst,
    input  logic en_i,
    output logic oe_o
);
    logic en_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_d <= 1'b0;
            oe_o <= 1'b0;
        end else begin
            en_d <= en_i;
            oe_o <= en_i | en_d;
        end
    end

    // R6: the pad follows the enable one cycle later
    assert_oe_follows_R6: assert property (@(posedge clk) disable iff (rst)
        en_i |=> oe_o);

    // R6: the drive window outlasts the enable by one cycle
    assert_oe_stretch_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(en_i) |=> oe_o);
endmodule

// File: rtl/hpm_seq.sv
module hpm_seq
    import hpm_pkg::*;
#(
    parameter int DATA_W = HP_DATA_W,
    parameter int CTRL_W = HP_CTRL_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [CTRL_W-1:0] req_ctrl,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              rdy_q,
    input  logic [DATA_W-1:0] bus_in,
    output logic              grant,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output hp_pins_t          pins,
    output logic              drv_en,
    output logic [DATA_W-1:0] dout
);
    localparam int PAD_W = DATA_W - CTRL_W;

    hp_state_e         state, state_n;
    logic              wr_q, wr_n;
    logic [CTRL_W-1:0] ctl_q, ctl_n;
    logic [DATA_W-1:0] wdat_q, wdat_n;
    logic              accept;

    assign accept = (state == ST_IDLE) && req_valid;

    always_comb begin
        wr_n   = accept ? req_write : wr_q;
        ctl_n  = accept ? req_ctrl  : ctl_q;
        wdat_n = accept ? req_wdata : wdat_q;
    end

    always_comb begin
        state_n = state;
        case (state)
            ST_IDLE:   if (req_valid) state_n = ST_LEAD1;
            ST_LEAD1:  state_n = ST_LEAD2;
            ST_LEAD2:  state_n = ST_SEL;
            ST_SEL:    state_n = ST_ADDR;
            ST_ADDR:   state_n = wr_q ? ST_STROBE : ST_WAIT;
            ST_WAIT:   if (rdy_q) state_n = ST_STROBE;
            ST_STROBE: state_n = ST_CLOSE;
            ST_CLOSE:  state_n = ST_IDLE;
            default:   state_n = ST_IDLE;
        endcase
    end

    // Every pin value is computed from the next state and stored, so each
    // pin leaves a flop.
    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            wr_q   <= 1'b0;
            ctl_q  <= '0;
            wdat_q <= '0;
            pins   <= '{cs_n: 1'b1, as_n: 1'b1, ds_n: 1'b1, rnw: 1'b1};
            drv_en <= 1'b0;
            dout   <= '0;
            grant  <= 1'b0;
            done   <= 1'b0;
            rdata  <= '0;
        end else begin
            state  <= state_n;
            wr_q   <= wr_n;
            ctl_q  <= ctl_n;
            wdat_q <= wdat_n;
            pins   <= pins_for(state_n, wr_n);
            drv_en <= drive_window(state_n, wr_n);
            if (state_n == ST_SEL || state_n == ST_ADDR)
                dout <= {{PAD_W{1'b0}}, ctl_n};
            else
                dout <= wdat_n;
            grant  <= accept;
            done   <= (state_n == ST_CLOSE);
            if (state == ST_STROBE && !wr_q)
                rdata <= bus_in;
        end
    end

    // R2: direction settled for two cycles when select falls
    assert_rnw_lead_R2: assert property (@(posedge clk) disable iff (rst)
        $fell(pins.cs_n) |-> (pins.rnw == $past(pins.rnw) && pins.rnw == $past(pins.rnw, 2)));

    // R2: a write direction changes exactly two cycles ahead of select
    assert_rnw_edge_R2: assert property (@(posedge clk) disable iff (rst)
        ($fell(pins.cs_n) && !pins.rnw) |-> $past(pins.rnw, 3));

    // R3: address strobe one cycle after select
    assert_as_after_cs_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(pins.as_n) |-> (!pins.cs_n && !$past(pins.cs_n) && $past(pins.cs_n, 2)));

    // R4: write data strobe one cycle after the address strobe
    assert_wr_ds_R4: assert property (@(posedge clk) disable iff (rst)
        ($fell(pins.ds_n) && !pins.rnw) |-> (!$past(pins.as_n) && $past(pins.as_n, 2)));

    // R4: data strobe is a single-cycle low pulse
    assert_ds_width_R4: assert property (@(posedge clk) disable iff (rst)
        !pins.ds_n |=> pins.ds_n);

    // R7: read data strobe only after registered ready
    assert_rd_ready_R7: assert property (@(posedge clk) disable iff (rst)
        ($fell(pins.ds_n) && pins.rnw) |-> $past(rdy_q));

    // R9: done is a lone pulse with the interface quiet
    assert_done_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        done |-> (pins.cs_n && pins.as_n && pins.ds_n));

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
endmodule

// File: rtl/hpm_master.sv
module hpm_master
    import hpm_pkg::*;
#(
    parameter int DATA_W = HP_DATA_W,
    parameter int CTRL_W = HP_CTRL_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [CTRL_W-1:0] req_ctrl,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_grant,
    output logic              rsp_done,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              hp_cs_n,
    output logic              hp_as_n,
    output logic              hp_ds_n,
    output logic              hp_rnw,
    output logic [DATA_W-1:0] hp_dout,
    output logic              hp_oe,
    input  logic [DATA_W-1:0] hp_din,
    input  logic              hp_ready,
    input  logic              hp_ack,
    input  logic              hp_svc,
    output logic              ack_seen,
    output logic              svc_pending
);
    localparam int N_HS = 3;

    logic [N_HS-1:0] hs_raw, hs_q;
    hp_pins_t        pins;
    logic            drv_en;

    assign hs_raw = {hp_svc, hp_ack, hp_ready};

    for (genvar g = 0; g < N_HS; g++) begin : g_hs
        hpm_insync #(.W(1)) u_sync (
            .clk (clk),
            .rst (rst),
            .d   (hs_raw[g]),
            .q   (hs_q[g])
        );
    end

    hpm_seq #(.DATA_W(DATA_W), .CTRL_W(CTRL_W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_ctrl  (req_ctrl),
        .req_wdata (req_wdata),
        .rdy_q     (hs_q[0]),
        .bus_in    (hp_din),
        .grant     (req_grant),
        .done      (rsp_done),
        .rdata     (rsp_rdata),
        .pins      (pins),
        .drv_en    (drv_en),
        .dout      (hp_dout)
    );

    hpm_oe_stage u_oe (
        .clk  (clk),
        .rst  (rst),
        .en_i (drv_en),
        .oe_o (hp_oe)
    );

    assign hp_cs_n     = pins.cs_n;
    assign hp_as_n     = pins.as_n;
    assign hp_ds_n     = pins.ds_n;
    assign hp_rnw      = pins.rnw;
    assign ack_seen    = hs_q[1];
    assign svc_pending = hs_q[2];

    // R6: the pad is released while the data strobe of a read is low
    assert_no_clash_R6: assert property (@(posedge clk) disable iff (rst)
        (!hp_ds_n && hp_rnw) |-> !hp_oe);

    // R10: registered handshake copies
    assert_ack_reg_R10: assert property (@(posedge clk) disable iff (rst)
        ack_seen == $past(hp_ack));
endmodule

// File: tb/tb_hpm_master.sv
module tb_hpm_master;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 16;
    localparam int CW = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0, req_write = 1'b0;
    logic [CW-1:0] req_ctrl = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          req_grant, rsp_done;
    logic [DW-1:0] rsp_rdata;
    logic          hp_cs_n, hp_as_n, hp_ds_n, hp_rnw, hp_oe;
    logic [DW-1:0] hp_dout, hp_din;
    logic          hp_ready = 1'b0, hp_ack = 1'b0, hp_svc = 1'b0;
    logic          ack_seen, svc_pending;

    hpm_master dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_ctrl(req_ctrl), .req_wdata(req_wdata), .req_grant(req_grant),
        .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .hp_cs_n(hp_cs_n),
        .hp_as_n(hp_as_n), .hp_ds_n(hp_ds_n), .hp_rnw(hp_rnw),
        .hp_dout(hp_dout), .hp_oe(hp_oe), .hp_din(hp_din),
        .hp_ready(hp_ready), .hp_ack(hp_ack), .hp_svc(hp_svc),
        .ack_seen(ack_seen), .svc_pending(svc_pending)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int checks = 0;
    int fails  = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    typedef struct {
        bit          wr;
        bit [CW-1:0] ctl;
        bit [DW-1:0] data;
    } item_t;
    item_t sbq[$];

    // Behavioural responder
    logic [DW-1:0] rd_word = '0;
    int            rd_delay = 0;
    logic          resp_drv;
    assign resp_drv = !hp_cs_n && !hp_ds_n && hp_rnw;
    assign hp_din   = resp_drv ? rd_word : '0;

    logic p_cs = 1'b1, p_as = 1'b1, p_ds = 1'b1, p_rnw = 1'b1;
    int   c_rnw = -100, c_cs = -100, c_as = -100, c_dsf = -100, c_rise = -100, c_rdy = -100;
    int   rdy_cnt = 0;
    bit   rd_active = 1'b0;
    logic [CW-1:0] cap_ctl = '0;
    logic [DW-1:0] cap_wdata = '0;

    // Monitor and scoreboard
    always @(negedge clk) begin
        if (!rst) begin
            item_t it;
            it = (sbq.size() > 0) ? sbq[0] : '{wr: 1'b0, ctl: '0, data: '0};
            if (hp_rnw != p_rnw) c_rnw = cyc;
            if (resp_drv) check(!hp_oe, "R6", "bus clash", int'(hp_oe), 0);

            if (p_cs && !hp_cs_n) begin
                c_cs = cyc;
                if (it.wr) check(!hp_rnw && (cyc - c_rnw == 2), "R2", "rnw lead", cyc - c_rnw, 2);
                else       check(hp_rnw, "R2", "rnw read level", int'(hp_rnw), 1);
                check(hp_oe && hp_dout == {{(DW-CW){1'b0}}, it.ctl}, "R5", "ctrl at select",
                      int'(hp_dout), int'(it.ctl));
            end

            if (p_as && !hp_as_n) begin
                c_as = cyc;
                check(cyc - c_cs == 1, "R3", "as after cs", cyc - c_cs, 1);
                check(hp_oe && hp_dout == {{(DW-CW){1'b0}}, it.ctl}, "R5", "ctrl at strobe",
                      int'(hp_dout), int'(it.ctl));
                cap_ctl = hp_dout[CW-1:0];
                if (hp_rnw) begin
                    rd_active = 1'b1;
                    rdy_cnt   = rd_delay;
                    if (rdy_cnt == 0) begin
                        hp_ready = 1'b1;
                        c_rdy    = cyc;
                    end
                end
            end else if (rd_active && !hp_ready) begin
                rdy_cnt--;
                if (rdy_cnt <= 0) begin
                    hp_ready = 1'b1;
                    c_rdy    = cyc;
                end
            end

            if (hp_rnw && cyc == c_as + 1)
                check(!hp_oe, "R6", "read bus released", int'(hp_oe), 0);

            if (p_ds && !hp_ds_n) begin
                c_dsf = cyc;
                if (it.wr) begin
                    check(cyc - c_as == 1, "R4", "ds after as", cyc - c_as, 1);
                    check(hp_oe && hp_dout == it.data, "R4", "write word", int'(hp_dout), int'(it.data));
                end else begin
                    check(cyc - c_rdy == 2, "R7", "ds after ready", cyc - c_rdy, 2);
                    check(!hp_oe, "R6", "oe during read strobe", int'(hp_oe), 0);
                end
            end

            if (!p_ds && hp_ds_n) begin
                c_rise = cyc;
                check(cyc - c_dsf == 1, "R4", "ds width", cyc - c_dsf, 1);
                check(rsp_done && hp_cs_n && hp_as_n, "R9", "done at release", int'(rsp_done), 1);
                if (it.wr) begin
                    check(hp_oe, "R6", "write drive stretch", int'(hp_oe), 1);
                    cap_wdata = hp_dout;
                end
            end

            if (cyc == c_rise + 1) begin
                check(!rsp_done, "R9", "done one cycle", int'(rsp_done), 0);
                check(!hp_oe, "R6", "oe off after done", int'(hp_oe), 0);
            end

            if (rsp_done && sbq.size() > 0) begin
                item_t e;
                e = sbq.pop_front();
                check(cap_ctl == e.ctl, "R5", "ctrl captured", int'(cap_ctl), int'(e.ctl));
                if (e.wr) check(cap_wdata == e.data, "R4", "write captured", int'(cap_wdata), int'(e.data));
                else      check(rsp_rdata == e.data, "R8", "read data", int'(rsp_rdata), int'(e.data));
            end

            if (hp_cs_n) begin
                hp_ready  = 1'b0;
                rd_active = 1'b0;
            end
            p_cs = hp_cs_n; p_as = hp_as_n; p_ds = hp_ds_n; p_rnw = hp_rnw;
        end
    end

    // Driver: pushes the expected item, then issues the request
    task automatic do_xfer(input bit wr, input bit [CW-1:0] ctl,
                           input bit [DW-1:0] data, input int rdelay);
        int k;
        @(negedge clk);
        sbq.push_back('{wr: wr, ctl: ctl, data: data});
        rd_word   = data;
        rd_delay  = rdelay;
        req_valid = 1'b1;
        req_write = wr;
        req_ctrl  = ctl;
        req_wdata = wr ? data : 16'h0;
        k = cyc;
        @(negedge clk);
        check(req_grant && cyc == k + 1, "R9", "grant timing", int'(req_grant), 1);
        req_valid = 1'b0;
        @(negedge clk);
        check(!req_grant, "R9", "grant one cycle", int'(req_grant), 0);
        while (!rsp_done) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(hp_cs_n && hp_as_n && hp_ds_n && hp_rnw, "R1", "pins idle",
              int'({hp_cs_n, hp_as_n, hp_ds_n, hp_rnw}), 15);
        check(!hp_oe && !rsp_done && !req_grant && !ack_seen && !svc_pending, "R1", "flags low",
              int'({hp_oe, rsp_done, req_grant, ack_seen, svc_pending}), 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        // R10: handshake registration
        hp_ack = 1'b1;
        @(negedge clk);
        check(ack_seen, "R10", "ack follows", int'(ack_seen), 1);
        hp_ack = 1'b0; hp_svc = 1'b1;
        @(negedge clk);
        check(!ack_seen && svc_pending, "R10", "svc follows", int'({ack_seen, svc_pending}), 1);
        hp_svc = 1'b0;
        @(negedge clk);
        check(!svc_pending, "R10", "svc clears", int'(svc_pending), 0);

        do_xfer(1'b1, 2'd1, 16'hA5A5, 0);
        do_xfer(1'b1, 2'd3, 16'hFFFF, 0);
        do_xfer(1'b1, 2'd0, 16'h0000, 0);
        do_xfer(1'b0, 2'd2, 16'h1234, 0);
        do_xfer(1'b0, 2'd1, 16'hBEEF, 4);
        do_xfer(1'b0, 2'd3, 16'h0001, 1);
        for (int i = 0; i < 24; i++) begin
            do_xfer(1'($urandom_range(0, 1)), 2'($urandom_range(0, 3)),
                    16'($urandom), int'($urandom_range(0, 6)));
        end
        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule